// File: doc/BRIEF.md
# Hot-Plug Slot Power Sequencer

This block switches the supply of two hot-plug expansion slots on or off without software involvement. One strobe starts a pass. The level of the enable input, captured at that strobe, picks the direction. For each slot in turn, the sequencer programs a register-mapped I2C master engine so that the engine performs a one-byte register write to a fixed slot power controller on the I2C bus.

The sequencer talks to the engine through a plain register port. It issues one read or write at a time and holds the request until the engine acknowledges it. Between programming steps it polls the engine's status register. If a poll is not yet satisfied, it retries at a fixed interval, which a clock-cycle prescaler sets. After a bounded number of retries it gives up. The first failure ends the pass at once, and the failure is reported as one of three error codes.

At the end of every pass, a one-cycle done pulse appears together with a success flag and the error code. Both values stay unchanged until the next pass begins.

Top module: `slot_pwr_seq`

## Requirements
- R1: After reset, busy, done, ok, bus_req and err_code are all 0.
- R2: Each slot receives four writes in this fixed order:
  - a mode write to address 0x0A0026 with data 0x0176000000000000;
  - a command write to address 0x0A0025 with data 0xD0C4000200000000. In this word, byte 0 is the flag byte 0xD0, bits 8..15 hold the device address 0xC4 with bit 15 cleared, and bits 16..31 hold the transfer length 2. Bit 0 is the most significant bit of the 64-bit word.
  - a write to the FIFO at address 0x0A0024 carrying the controller register offset in bits 0..7;
  - a FIFO write carrying the power byte in bits 0..7.

  The slots are handled in order, with offset 0x05 first and 0x06 second.
- R3: The power byte is 0x55 when enable was high at the accepted start and 0x54 when it was low.
- R4: A readiness poll reads the status register at 0x0A002B. It runs once before the mode write of each slot and once after the power byte of each slot. The poll is satisfied when bit 7 (complete) is set and none of bits 0..6 or bit 8 is set. If complete is set together with any of those error bits, the pass ends with err_code 2. While complete is clear, the error bits are ignored.
- R5: After the offset write, a drain poll reads the status register until the FIFO count in bits 28..31 is zero. If the retries run out, the pass ends with err_code 1.
- R6: A poll makes one initial read and at most POLL_MAX retries. Consecutive reads of one poll are at least TICK_DIV cycles apart, and no bus request is made while the sequencer is waiting. If a readiness poll runs out of retries, the pass ends with err_code 3.
- R7: After a failure, the sequencer issues no further bus access. The remaining slot is left untouched.
- R8: At the end of every pass, done is high for exactly one cycle. At that point ok is 1 exactly when err_code is 0, and both values hold until the next accepted start.
- R9: A start strobe that arrives while busy is ignored. It does not change the captured direction and does not begin another pass.
- R10: bus_req stays high, with address and write data stable, until the cycle in which bus_ack is sampled high. That cycle completes the access, and for a read it is the cycle in which bus_rdata is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Strobe that begins a pass when idle |
| enable | input | 1 | Direction captured at start: 1 powers the slots on, 0 powers them off |
| busy | output | 1 | A pass is in progress |
| done | output | 1 | One-cycle pulse at the end of a pass |
| ok | output | 1 | The last pass finished without error |
| err_code | output | 2 | Result of the last pass: 0 none, 1 FIFO not drained, 2 error bit, 3 complete timeout |
| bus_req | output | 1 | Register access request toward the engine |
| bus_we | output | 1 | 1 for a write, 0 for a read |
| bus_addr | output | 24 | Engine register address |
| bus_wdata | output | 64 | Write data |
| bus_rdata | input | 64 | Read data, valid with bus_ack |
| bus_ack | input | 1 | Access complete |

## Verification
Two of the block's decisions can fall on the same status read. One read can exhaust the retry budget while its error bits are set and its complete bit is clear. The bench provokes this by filling every not-ready response with random error bits, and it expects a timeout code, never an error-bit code. The other collision is a start strobe that lands while a pass is running. The bench pulses start with the opposite direction mid-pass, and it judges the result by the power bytes written and by the absence of any second pass after done.

// File: rtl/slot_pwr_pkg.sv
package slot_pwr_pkg;
  localparam int REG_W  = 64;
  localparam int ADDR_W = 24;

  localparam logic [ADDR_W-1:0] A_FIFO = 24'h0A0024;
  localparam logic [ADDR_W-1:0] A_CMD  = 24'h0A0025;
  localparam logic [ADDR_W-1:0] A_MODE = 24'h0A0026;
  localparam logic [ADDR_W-1:0] A_STAT = 24'h0A002B;

  localparam logic [7:0]  DEV_ADDR  = 8'hC4;
  localparam logic [7:0]  CMD_FLAGS = 8'hD0;
  localparam logic [7:0]  BYTE_OFF  = 8'h54;
  localparam logic [7:0]  BYTE_ON   = 8'h55;
  localparam logic [7:0]  BASE_OFS  = 8'h05;
  localparam logic [31:0] MODE_CFG  = 32'h0176_0000;
  localparam logic [15:0] XFER_LEN  = 16'd2;

  // status bit positions, MSB-first numbering
  localparam int SB_COMPLETE = 7;
  localparam int SB_CNT_HI   = 28;

  localparam int STEPS = 7;

  typedef enum logic [1:0] {
    ERR_NONE  = 2'd0,
    ERR_DRAIN = 2'd1,
    ERR_FLAG  = 2'd2,
    ERR_TMO   = 2'd3
  } err_e;

  typedef enum logic [2:0] {K_RDY, K_MODE, K_CMD, K_OFS, K_DRN, K_DATA} kind_e;

  function automatic int lsb_of(input int msb_pos);
    return REG_W - 1 - msb_pos;
  endfunction

  function automatic logic [REG_W-1:0] top_byte(input logic [7:0] b);
    return {b, {(REG_W-8){1'b0}}};
  endfunction

  function automatic logic [REG_W-1:0] mode_word();
    return {MODE_CFG, {(REG_W-32){1'b0}}};
  endfunction

  function automatic logic [REG_W-1:0] cmd_word(input logic [7:0] dev);
    return {CMD_FLAGS, dev & 8'hFE, XFER_LEN, {(REG_W-32){1'b0}}};
  endfunction

  function automatic logic st_complete(input logic [REG_W-1:0] s);
    return s[lsb_of(SB_COMPLETE)];
  endfunction

  function automatic logic st_flagged(input logic [REG_W-1:0] s);
    logic hit;
    hit = 1'b0;
    for (int p = 0; p <= 8; p++)
      if (p != SB_COMPLETE) hit = hit | s[lsb_of(p)];
    return hit;
  endfunction

  function automatic logic [3:0] st_fifo_cnt(input logic [REG_W-1:0] s);
    return s[lsb_of(SB_CNT_HI) -: 4];
  endfunction

  function automatic kind_e step_kind(input logic [2:0] st);
    case (st)
      3'd0:    return K_RDY;
      3'd1:    return K_MODE;
      3'd2:    return K_CMD;
      3'd3:    return K_OFS;
      3'd4:    return K_DRN;
      3'd5:    return K_DATA;
      default: return K_RDY;
    endcase
  endfunction
endpackage

// File: rtl/sps_tick_timer.sv
module sps_tick_timer #(
  parameter int TICK_DIV = 100000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm,
  output logic running,
  output logic expire
);
  localparam int CW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [CW-1:0] RELOAD = CW'(TICK_DIV - 1);

  logic [CW-1:0] cnt;

  assign expire = running && (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt     <= '0;
      running <= 1'b0;
    end else if (arm) begin
      cnt     <= RELOAD;
      running <= 1'b1;
    end else if (expire) begin
      running <= 1'b0;
    end else if (running) begin
      cnt <= cnt - 1'b1;
    end
  end
endmodule

// File: rtl/sps_bus_master.sv
module sps_bus_master
  import slot_pwr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              issue,
  input  logic              op_we,
  input  logic [ADDR_W-1:0] op_addr,
  input  logic [REG_W-1:0]  op_wdata,
  input  logic              bus_ack,
  output logic              bus_req,
  output logic              bus_we,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [REG_W-1:0]  bus_wdata,
  output logic              fin
);
  assign fin = bus_req && bus_ack;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bus_req   <= 1'b0;
      bus_we    <= 1'b0;
      bus_addr  <= '0;
      bus_wdata <= '0;
    end else if (fin) begin
      bus_req <= 1'b0;
    end else if (issue && !bus_req) begin
      bus_req   <= 1'b1;
      bus_we    <= op_we;
      bus_addr  <= op_addr;
      bus_wdata <= op_wdata;
    end
  end
endmodule

// File: rtl/sps_status_eval.sv
module sps_status_eval
  import slot_pwr_pkg::*;
(
  input  logic [REG_W-1:0] stat,
  output logic             complete,
  output logic             flagged,
  output logic             drained
);
  assign complete = st_complete(stat);
  assign flagged  = st_flagged(stat);
  assign drained  = (st_fifo_cnt(stat) == 4'd0);
endmodule

// File: rtl/slot_pwr_seq.sv
module slot_pwr_seq #(
  parameter int NUM_SLOTS = 2,
  parameter int TICK_DIV  = 100000,
  parameter int POLL_MAX  = 100
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             start,
  input  logic                             enable,
  output logic                             busy,
  output logic                             done,
  output logic                             ok,
  output logic [1:0]                       err_code,
  output logic                             bus_req,
  output logic                             bus_we,
  output logic [slot_pwr_pkg::ADDR_W-1:0]  bus_addr,
  output logic [slot_pwr_pkg::REG_W-1:0]   bus_wdata,
  input  logic [slot_pwr_pkg::REG_W-1:0]   bus_rdata,
  input  logic                             bus_ack
);
  import slot_pwr_pkg::*;

  localparam int SW = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1;
  localparam int RW = $clog2(POLL_MAX + 1) > 0 ? $clog2(POLL_MAX + 1) : 1;
  localparam logic [2:0]    LAST_STEP = 3'(STEPS - 1);
  localparam logic [SW-1:0] LAST_SLOT = SW'(NUM_SLOTS - 1);
  localparam logic [RW-1:0] RETRY_CAP = RW'(POLL_MAX);

  typedef enum logic [1:0] {SQ_IDLE, SQ_ISSUE, SQ_WAIT, SQ_PAUSE} sq_e;

  sq_e           state;
  logic [SW-1:0] slot;
  logic [2:0]    step;
  logic [RW-1:0] retries;
  logic          en_q;

  // named internal events
  kind_e             kind;
  logic              is_poll;
  logic              fin;
  logic              issue;
  logic              st_done, st_flag, st_drained;
  logic              poll_pass, poll_hard, retry_left;
  logic              tmr_arm, tmr_run, tmr_exp;
  logic              op_we;
  logic [ADDR_W-1:0] op_addr;
  logic [REG_W-1:0]  op_wdata;
  logic [7:0]        slot_ofs;

  assign busy     = (state != SQ_IDLE);
  assign issue    = (state == SQ_ISSUE);
  assign kind     = step_kind(step);
  assign is_poll  = (kind == K_RDY) || (kind == K_DRN);
  assign slot_ofs = BASE_OFS + 8'(slot);

  always_comb begin
    op_we    = 1'b1;
    op_addr  = A_FIFO;
    op_wdata = '0;
    case (kind)
      K_RDY, K_DRN: begin op_we = 1'b0; op_addr = A_STAT; end
      K_MODE:       begin op_addr = A_MODE; op_wdata = mode_word(); end
      K_CMD:        begin op_addr = A_CMD;  op_wdata = cmd_word(DEV_ADDR); end
      K_OFS:        op_wdata = top_byte(slot_ofs);
      K_DATA:       op_wdata = top_byte(en_q ? BYTE_ON : BYTE_OFF);
      default:      op_addr = A_FIFO;
    endcase
  end

  sps_status_eval u_eval (
    .stat     (bus_rdata),
    .complete (st_done),
    .flagged  (st_flag),
    .drained  (st_drained)
  );

  assign poll_pass  = (kind == K_RDY) ? (st_done && !st_flag) : st_drained;
  assign poll_hard  = (kind == K_RDY) && st_done && st_flag;
  assign retry_left = (retries != RETRY_CAP);
  assign tmr_arm    = (state == SQ_WAIT) && fin && is_poll && !poll_pass
                      && !poll_hard && retry_left;

  sps_bus_master u_bus (
    .clk       (clk),
    .rst_n     (rst_n),
    .issue     (issue),
    .op_we     (op_we),
    .op_addr   (op_addr),
    .op_wdata  (op_wdata),
    .bus_ack   (bus_ack),
    .bus_req   (bus_req),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .fin       (fin)
  );

  sps_tick_timer #(.TICK_DIV(TICK_DIV)) u_tmr (
    .clk     (clk),
    .rst_n   (rst_n),
    .arm     (tmr_arm),
    .running (tmr_run),
    .expire  (tmr_exp)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= SQ_IDLE;
      slot     <= '0;
      step     <= '0;
      retries  <= '0;
      en_q     <= 1'b0;
      done     <= 1'b0;
      ok       <= 1'b0;
      err_code <= ERR_NONE;
    end else begin
      done <= 1'b0;
      case (state)
        SQ_IDLE: if (start) begin
          en_q     <= enable;
          slot     <= '0;
          step     <= '0;
          retries  <= '0;
          ok       <= 1'b0;
          err_code <= ERR_NONE;
          state    <= SQ_ISSUE;
        end
        SQ_ISSUE: state <= SQ_WAIT;
        SQ_WAIT: if (fin) begin
          if (is_poll && poll_hard) begin
            err_code <= ERR_FLAG;
            done     <= 1'b1;
            state    <= SQ_IDLE;
          end else if (is_poll && !poll_pass) begin
            if (retry_left) begin
              retries <= retries + 1'b1;
              state   <= SQ_PAUSE;
            end else begin
              err_code <= (kind == K_RDY) ? ERR_TMO : ERR_DRAIN;
              done     <= 1'b1;
              state    <= SQ_IDLE;
            end
          end else begin
            retries <= '0;
            if (step != LAST_STEP) begin
              step  <= step + 1'b1;
              state <= SQ_ISSUE;
            end else if (slot != LAST_SLOT) begin
              step  <= '0;
              slot  <= slot + 1'b1;
              state <= SQ_ISSUE;
            end else begin
              ok    <= 1'b1;
              done  <= 1'b1;
              state <= SQ_IDLE;
            end
          end
        end
        SQ_PAUSE: if (tmr_exp) state <= SQ_ISSUE;
        default:  state <= SQ_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/slot_pwr_seq_chk.sv
module slot_pwr_seq_chk #(
  parameter int POLL_MAX = 100,
  parameter int RW       = 7
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          busy,
  input logic          done,
  input logic          ok,
  input logic [1:0]    err_code,
  input logic          bus_req,
  input logic          bus_ack,
  input logic [23:0]   bus_addr,
  input logic [63:0]   bus_wdata,
  input logic          en_lat,
  input logic [RW-1:0] retry_cnt,
  input logic          tmr_run
);
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R8
  AST_OK_MATCHES_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (ok == (err_code == 2'd0))); // R8
  AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start && !done) |=> ($stable(err_code) && $stable(ok))); // R8
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_ack) |=> (bus_req && $stable(bus_addr) && $stable(bus_wdata))); // R10
  AST_QUIET_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_run |-> !bus_req); // R6
  AST_RETRY_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    int'(retry_cnt) <= POLL_MAX); // R6
  AST_EN_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> $stable(en_lat)); // R9
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !bus_req); // R7
endmodule

bind slot_pwr_seq slot_pwr_seq_chk #(.POLL_MAX(POLL_MAX), .RW(RW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (start),
  .busy      (busy),
  .done      (done),
  .ok        (ok),
  .err_code  (err_code),
  .bus_req   (bus_req),
  .bus_ack   (bus_ack),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .en_lat    (en_q),
  .retry_cnt (retries),
  .tmr_run   (tmr_run)
);

// File: tb/tb_slot_pwr_seq.sv
module tb_slot_pwr_seq;
  localparam int TICK = 8;
  localparam int PMAX = 3;
  localparam logic [63:0] COMPLETE = 64'h1 << 56;
  localparam logic [63:0] ERRMASK  = (64'hFE << 56) | (64'h1 << 55);

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        enable = 1'b0;
  logic        busy, done, ok, bus_req, bus_we;
  logic [1:0]  err_code;
  logic [23:0] bus_addr;
  logic [63:0] bus_wdata;
  logic [63:0] bus_rdata = '0;
  logic        bus_ack = 1'b0;

  slot_pwr_seq #(.NUM_SLOTS(2), .TICK_DIV(TICK), .POLL_MAX(PMAX)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .enable(enable),
    .busy(busy), .done(done), .ok(ok), .err_code(err_code),
    .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_ack(bus_ack)
  );

  always #10 clk = ~clk;

  int nchk = 0, nfail = 0, cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit cond, input string tag, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (!cond) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // engine model
  int sc_ready, sc_drain, sc_err_at, sc_err_pos;
  int ready_left, drain_left, rpoll_idx, fifo_wr, nw, nreads, lat_left;
  int last_read_cyc;
  bit prev_busy_read, gap_viol, hold_viol, prev_req, prev_ack;
  logic [23:0] wl_addr [16];
  logic [63:0] wl_data [16];
  logic [23:0] prev_addr;
  logic [63:0] prev_wdata;

  function automatic logic [63:0] rnd64();
    return {$urandom, $urandom};
  endfunction

  always @(negedge clk) begin
    if (rst_n && bus_req && prev_req && !prev_ack &&
        (bus_addr != prev_addr || bus_wdata != prev_wdata)) hold_viol = 1;
    prev_req = bus_req; prev_ack = bus_ack;
    prev_addr = bus_addr; prev_wdata = bus_wdata;
    if (!rst_n) bus_ack = 0;
    else if (bus_ack) bus_ack = 0;
    else if (bus_req) begin
      if (lat_left > 0) lat_left--;
      else begin
        lat_left = $urandom % 3;
        bus_ack = 1;
        if (bus_we) begin
          if (nw < 16) begin wl_addr[nw] = bus_addr; wl_data[nw] = bus_wdata; end
          nw++;
          if (bus_addr == 24'h0A0024) begin
            fifo_wr++;
            if (fifo_wr % 2 == 1) drain_left = sc_drain;
          end
          prev_busy_read = 0;
        end else begin
          nreads++;
          if (prev_busy_read && (cyc - last_read_cyc) < TICK) gap_viol = 1;
          last_read_cyc = cyc;
          if (fifo_wr % 2 == 1) begin
            if (drain_left > 0) begin
              drain_left--;
              bus_rdata = (rnd64() & ~(64'hF << 32)) | (64'(1 + $urandom % 15) << 32);
              prev_busy_read = 1;
            end else begin
              bus_rdata = rnd64() & ~(64'hF << 32);
              prev_busy_read = 0;
            end
          end else begin
            if (ready_left > 0) begin
              ready_left--;
              bus_rdata = rnd64() & ~COMPLETE;  // error bits may be set while incomplete
              prev_busy_read = 1;
            end else begin
              bus_rdata = (rnd64() & ~ERRMASK & ~(64'hF << 32)) | COMPLETE;
              if (rpoll_idx == sc_err_at) bus_rdata |= 64'h1 << (63 - sc_err_pos);
              rpoll_idx++;
              ready_left = sc_ready;
              prev_busy_read = 0;
            end
          end
        end
      end
    end
  end

  function automatic int exp_code(input int r, input int d, input int e);
    if (r > PMAX) return 3;
    if (e == 0) return 2;
    if (d > PMAX) return 1;
    if (e >= 1 && e <= 3) return 2;
    return 0;
  endfunction

  function automatic int exp_nw(input int r, input int d, input int e);
    if (r > PMAX || e == 0) return 0;
    if (d > PMAX) return 3;
    if (e >= 1 && e <= 3) return 4 * ((e + 1) / 2);
    return 8;
  endfunction

  function automatic logic [63:0] exp_wdata(input int i, input bit en);
    case (i % 4)
      0: return 64'h0176_0000 << 32;
      1: return {8'hD0, 8'hC4 & 8'hFE, 16'd2, 32'd0};
      2: return 64'(8'h05 + i / 4) << 56;
      default: return 64'(en ? 8'h55 : 8'h54) << 56;
    endcase
  endfunction

  function automatic logic [23:0] exp_waddr(input int i);
    case (i % 4)
      0: return 24'h0A0026;
      1: return 24'h0A0025;
      default: return 24'h0A0024;
    endcase
  endfunction

  task automatic run_pass(input bit en, input int r, input int d, input int e,
                          input int epos, input bit poke);
    int ec, en_w, w;
    sc_ready = r; sc_drain = d; sc_err_at = e; sc_err_pos = epos;
    ready_left = r; drain_left = d; rpoll_idx = 0; fifo_wr = 0;
    nw = 0; nreads = 0; gap_viol = 0; hold_viol = 0; prev_busy_read = 0;
    @(negedge clk); start = 1; enable = en;
    @(negedge clk); start = 0; enable = $urandom % 2;
    w = 0;
    while (!done && w < 20000) begin
      if (poke && w == 6) begin start = 1; enable = !en; end
      else start = 0;
      @(negedge clk); w++;
    end
    start = 0;
    ec = exp_code(r, d, e);
    en_w = exp_nw(r, d, e);
    chk(done == 1, "R8 done pulse seen", 64'(done), 1);
    chk(err_code == 2'(ec), ec == 3 ? "R6 timeout code" : ec == 1 ? "R5 drain code" :
        ec == 2 ? "R4 error-bit code" : "R8 success code", 64'(err_code), 64'(ec));
    chk(ok == (ec == 0), "R8 ok flag", 64'(ok), 64'(ec == 0));
    @(negedge clk);
    chk(done == 0, "R8 done one cycle", 64'(done), 0);
    repeat (4 * TICK) @(negedge clk);
    chk(nw == en_w, "R7 write count after end", 64'(nw), 64'(en_w));
    chk(busy == 0, "R9 no second pass", 64'(busy), 0);
    chk(err_code == 2'(ec), "R8 result held", 64'(err_code), 64'(ec));
    for (int i = 0; i < en_w && i < nw; i++) begin
      chk(wl_addr[i] == exp_waddr(i), "R2 write address", 64'(wl_addr[i]), 64'(exp_waddr(i)));
      chk(wl_data[i] == exp_wdata(i, en), (i % 4 == 3) ? "R3 power byte" : "R2 write data",
          wl_data[i], exp_wdata(i, en));
    end
    chk(!gap_viol, "R6 retry spacing", 64'(gap_viol), 0);
    chk(!hold_viol, "R10 request hold", 64'(hold_viol), 0);
    if (ec == 3) chk(nreads == PMAX + 1, "R6 read count on timeout", 64'(nreads), 64'(PMAX + 1));
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    nfail++;
    $display("FAIL R8 watchdog expired actual=hung expected=finished");
    $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    void'($urandom(32'h5107_0042));
    lat_left = 0;
    repeat (3) @(negedge clk);
    chk(busy == 0 && done == 0 && ok == 0 && bus_req == 0 && err_code == 0,
        "R1 reset state", {busy, done, ok, bus_req, err_code}, 0);
    rst_n = 1;
    @(negedge clk);
    // directed corners
    run_pass(1, 0, 0, 9, 0, 0);          // clean power-on
    run_pass(0, 1, 2, 9, 0, 0);          // clean power-off with retries
    run_pass(1, PMAX, PMAX, 9, 0, 0);    // last allowed retry passes
    run_pass(1, PMAX + 1, 0, 9, 0, 0);   // R6 timeout
    run_pass(0, 0, PMAX + 1, 9, 0, 0);   // R5 drain failure
    run_pass(1, 0, 0, 0, 8, 0);          // R4 error bit 8 on first poll
    run_pass(1, 0, 0, 3, 0, 0);          // R7 error after last slot
    run_pass(0, 0, 0, 2, 6, 0);          // R7 error before second slot
    run_pass(1, 1, 1, 9, 0, 1);          // R9 start poke while busy
    run_pass(0, 0, 0, 9, 0, 1);          // R9 poke, off direction
    // constrained random
    for (int k = 0; k < 20; k++) begin
      int idx;
      idx = $urandom % 8;
      run_pass($urandom % 2, $urandom % (PMAX + 2), $urandom % (PMAX + 2),
               $urandom % 6, (idx < 7) ? idx : 8, $urandom % 2);
    end
    $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule